// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Controller

This block looks after a single DRAM bank. It remembers whether the bank's row buffer holds a row, and which row that is. It turns each read or write request into the command steps the bank needs. A request names a 12-bit row and a 12-bit column, which together address a 4096 x 4096 bit array. Before issuing anything, the block sorts the request into one of three classes:

- **Hit:** the requested row is already open, so only a column command is needed.
- **Empty:** no row is open, so the block sends an activate and then a column command.
- **Conflict:** a different row is open, so the block sends a precharge, then an activate, then a column command.

The row address always goes out with the activate. The column address follows later with the read or write.

A policy input selects between two behaviours after each column command. With the input low, the row stays open so that later accesses to it are cheap. With it high, the bank is precharged right after every access. The input may change between requests.

Commands are spaced by one down-counter. Each issued command loads the minimum gap that must pass before the next command may issue. The request is acknowledged in the same cycle as its column command. At that moment the block also reports the request's class code, for use in statistics.

Top module: `bank_rowbuf_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request pending, `cmd_type` is 0 (no command) and `req_ready` is 0.
- R2: A request whose row equals the open row produces exactly one command: a read (code 2) when `req_write` is 0, or a write (code 3) when it is 1. It reports class code 00.
- R3: A request to a bank with no open row produces an activate (code 1) and then the column command. It reports class code 01.
- R4: A request to a row other than the open one produces a precharge (code 4), an activate and the column command, in that order. It reports class code 10.
- R5: With `close_page` low, the row stays open after the column command, and no precharge follows it.
- R6: With `close_page` high, a precharge follows every column command, after which the bank holds no open row.
- R7: A command that follows an activate issues exactly `T_RCD` cycles after that activate (default 3) when the gap is the binding constraint, and never earlier.
- R8: A command that follows a precharge issues exactly `T_RP` cycles after it (default 3) when the gap is the binding constraint, and never earlier.
- R9: A command that follows a read or write issues exactly `T_CP` cycles after it (default 2) when the gap is the binding constraint, and never earlier.
- R10: `req_ready` is high only in the cycle in which the request's column command is on `cmd_type`, and `acc_class` holds the request's class code in that cycle.
- R11: `cmd_addr` carries the row with an activate and the column with a read or write. It is 0 with a precharge.
- R12: A change of `close_page` made together with a new request governs that request's post-access behaviour.
- R13: No command issues without a pending request. When a request arrives with the bank idle and every gap already elapsed, its first command issues in the next cycle.
- R14: The column command is a read or a write according to `req_write`, whichever class the request has.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| close_page | input | 1 | 1 = precharge after each access, 0 = keep the row open |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (same cycle as its column command) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested column |
| cmd_type | output | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_addr | output | max(ROW_W,COL_W) | Address sent with the command |
| acc_class | output | 2 | Class of the current request: 00 hit, 01 empty, 10 conflict |

## Verification
The properties assume that a requester keeps `req_row`, `req_col`, `req_write` and `req_valid` unchanged from the cycle it raises `req_valid` until the cycle `req_ready` is seen. They also assume that `close_page` changes only while no request is in flight. The bench obeys both rules. It alters these inputs only just after the clock edge that ends an acknowledged cycle, or while `req_valid` is low. It sweeps every ordered pair from a small set of rows under open-page, close-page and alternating policies, and it inserts idle gaps of zero to two cycles. Because the bench derives every expected command cycle from the gaps and the arrival times, any early or late issue shows up as a mismatch.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    CLS_HIT      = 2'd0,
    CLS_EMPTY    = 2'd1,
    CLS_CONFLICT = 2'd2
  } cls_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_CPRE
  } st_e;

endpackage

// File: rtl/rowbuf_tracker.sv
module rowbuf_tracker
  import rowbuf_pkg::*;
#(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_en,
  input  logic             pre_en,
  input  logic [ROW_W-1:0] req_row,
  output logic             open_v,
  output logic [ROW_W-1:0] open_row,
  output cls_e             cls
);

  logic             open_v_d;
  logic [ROW_W-1:0] open_row_d;
  logic             row_en;

  always_comb begin
    open_v_d   = open_v;
    open_row_d = open_row;
    row_en     = 1'b0;
    if (act_en) begin
      open_v_d   = 1'b1;
      open_row_d = req_row;
      row_en     = 1'b1;
    end else if (pre_en) begin
      open_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_v <= 1'b0;
    end else begin
      open_v <= open_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_row <= '0;
    end else if (row_en) begin
      open_row <= open_row_d;
    end
  end

  always_comb begin
    if (!open_v) begin
      cls = CLS_EMPTY;
    end else if (open_row == req_row) begin
      cls = CLS_HIT;
    end else begin
      cls = CLS_CONFLICT;
    end
  end

endmodule

// File: rtl/rowbuf_gap_timer.sv
module rowbuf_gap_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_en) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/rowbuf_seq.sv
module rowbuf_seq
  import rowbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       close_page,
  input  cls_e       cls_in,
  input  logic       tmr_zero,
  output cmd_e       cmd,
  output logic       ack,
  output cls_e       cls_q
);

  st_e  st_q;
  st_e  st_d;
  cls_e cls_d;
  logic cls_en;

  always_comb begin
    st_d   = st_q;
    cmd    = CMD_NOP;
    ack    = 1'b0;
    cls_d  = cls_q;
    cls_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cls_en = 1'b1;
          cls_d  = cls_in;
          case (cls_in)
            CLS_HIT:   st_d = ST_COL;
            CLS_EMPTY: st_d = ST_ACT;
            default:   st_d = ST_PRE;
          endcase
        end
      end
      ST_PRE: begin
        if (tmr_zero) begin
          cmd  = CMD_PRE;
          st_d = ST_ACT;
        end
      end
      ST_ACT: begin
        if (tmr_zero) begin
          cmd  = CMD_ACT;
          st_d = ST_COL;
        end
      end
      ST_COL: begin
        if (tmr_zero) begin
          cmd  = req_write ? CMD_WR : CMD_RD;
          ack  = 1'b1;
          st_d = close_page ? ST_CPRE : ST_IDLE;
        end
      end
      ST_CPRE: begin
        if (tmr_zero) begin
          cmd  = CMD_PRE;
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q <= CLS_HIT;
    end else if (cls_en) begin
      cls_q <= cls_d;
    end
  end

endmodule

// File: rtl/bank_rowbuf_ctrl.sv
module bank_rowbuf_ctrl
  import rowbuf_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 12,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_CP  = 2,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_page,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [2:0]        cmd_type,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [1:0]        acc_class
);

  localparam int GAP_A  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int GAP_MX = (GAP_A > T_CP) ? GAP_A : T_CP;
  localparam int CNT_W  = (GAP_MX > 2) ? $clog2(GAP_MX) : 1;

  cmd_e             cmd;
  cls_e             cls_now;
  cls_e             cls_q;
  logic             tmr_zero;
  logic             issue;
  logic [CNT_W-1:0] gap_val;
  logic             open_v;
  logic [ROW_W-1:0] open_row;

  rowbuf_tracker #(.ROW_W(ROW_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_en   (cmd == CMD_ACT),
    .pre_en   (cmd == CMD_PRE),
    .req_row  (req_row),
    .open_v   (open_v),
    .open_row (open_row),
    .cls      (cls_now)
  );

  rowbuf_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .close_page (close_page),
    .cls_in     (cls_now),
    .tmr_zero   (tmr_zero),
    .cmd        (cmd),
    .ack        (req_ready),
    .cls_q      (cls_q)
  );

  always_comb begin
    issue = (cmd != CMD_NOP);
    case (cmd)
      CMD_ACT: gap_val = CNT_W'(T_RCD - 1);
      CMD_PRE: gap_val = CNT_W'(T_RP - 1);
      default: gap_val = CNT_W'(T_CP - 1);
    endcase
  end

  rowbuf_gap_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (issue),
    .load_val (gap_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    case (cmd)
      CMD_ACT:         cmd_addr = ADDR_W'(req_row);
      CMD_RD, CMD_WR:  cmd_addr = ADDR_W'(req_col);
      default:         cmd_addr = '0;
    endcase
  end

  assign cmd_type  = cmd;
  assign acc_class = cls_q;

endmodule

// File: rtl/bank_rowbuf_ctrl_chk.sv
module bank_rowbuf_ctrl_chk #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 12,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_CP   = 2,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ROW_W-1:0]  req_row,
  input logic [2:0]        cmd_type,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [1:0]        acc_class,
  input logic              open_v,
  input logic [ROW_W-1:0]  open_row
);

  localparam int GAP_A  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int GAP_MX = (GAP_A > T_CP) ? GAP_A : T_CP;
  localparam int SW     = $clog2(GAP_MX + 2) + 1;
  localparam logic [SW-1:0] SCAP = {SW{1'b1}};

  logic [SW-1:0] since_q;
  logic [2:0]    last_q;
  logic          seen_q;
  logic          is_col;

  assign is_col = (cmd_type == 3'd2) || (cmd_type == 3'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      last_q  <= '0;
      seen_q  <= 1'b0;
    end else if (cmd_type != 3'd0) begin
      since_q <= SW'(1);
      last_q  <= cmd_type;
      seen_q  <= 1'b1;
    end else if (since_q != SCAP) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_ack_col_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (is_col && req_valid && acc_class != 2'd3));

  p_rw_code_r14: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd_type == (req_write ? 3'd3 : 3'd2)));

  p_act_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type == 3'd1) |-> !open_v);

  p_pre_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type == 3'd4) |-> open_v);

  p_col_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (open_v && open_row == req_row));

  p_act_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type == 3'd1) |-> (cmd_addr == ADDR_W'(req_row)));

  p_act_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type != 3'd0 && seen_q && last_q == 3'd1) |-> (since_q >= SW'(T_RCD)));

  p_pre_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type != 3'd0 && seen_q && last_q == 3'd4) |-> (since_q >= SW'(T_RP)));

  p_col_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type != 3'd0 && seen_q && (last_q == 3'd2 || last_q == 3'd3))
      |-> (since_q >= SW'(T_CP)));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !open_v) |-> (cmd_type == 3'd0));

endmodule

bind bank_rowbuf_ctrl bank_rowbuf_ctrl_chk #(
  .ROW_W  (ROW_W),
  .COL_W  (COL_W),
  .T_RCD  (T_RCD),
  .T_RP   (T_RP),
  .T_CP   (T_CP),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_row   (req_row),
  .cmd_type  (cmd_type),
  .cmd_addr  (cmd_addr),
  .acc_class (acc_class),
  .open_v    (open_v),
  .open_row  (open_row)
);

// File: tb/tb_bank_rowbuf_ctrl.sv
`timescale 1ns/1ps
module tb_bank_rowbuf_ctrl;

  localparam int G_RCD = 3;
  localparam int G_RP  = 3;
  localparam int G_CP  = 2;

  logic        clk;
  logic        rst_n;
  logic        close_page;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [11:0] req_row;
  logic [11:0] req_col;
  logic [2:0]  cmd_type;
  logic [11:0] cmd_addr;
  logic [1:0]  acc_class;

  bank_rowbuf_ctrl #(
    .ROW_W(12), .COL_W(12), .T_RCD(G_RCD), .T_RP(G_RP), .T_CP(G_CP)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .close_page (close_page),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_row    (req_row),
    .req_col    (req_col),
    .cmd_type   (cmd_type),
    .cmd_addr   (cmd_addr),
    .acc_class  (acc_class)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  typedef struct {
    int typ;
    int addr;
    int when;
    int seqtag;
    int gaptag;
  } exp_t;

  exp_t exq[$];

  int  last_cyc = -1000;
  int  last_gap = 0;
  int  last_typ = 0;
  int  idle_from = 0;
  int  nxt = 0;
  bit  o_v = 1'b0;
  int  o_row = 0;
  bit  prev_pol = 1'b0;
  bit  monitor_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic string rtag(input int n);
    case (n)
      2:  return "R2";
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      9:  return "R9";
      12: return "R12";
      14: return "R14";
      default: return "R13";
    endcase
  endfunction

  // Model of command spacing: R7 R8 R9 bind via previous command's gap, R13 via arrival.
  task automatic exp_cmd(input int typ, input int addr, input int seqtag, output int at);
    int c;
    int gt;
    exp_t e;
    c  = nxt;
    gt = 13;
    if (last_cyc + last_gap >= c) begin
      c  = last_cyc + last_gap;
      gt = (last_typ == 1) ? 7 : (last_typ == 4) ? 8 : 9;
    end
    e.typ = typ; e.addr = addr; e.when = c; e.seqtag = seqtag; e.gaptag = gt;
    exq.push_back(e);
    last_cyc = c;
    last_typ = typ;
    last_gap = (typ == 1) ? G_RCD : (typ == 4) ? G_RP : G_CP;
    nxt = c + 1;
    at = c;
  endtask

  // Command monitor: type per R2/R3/R4/R6, address per R11, cycle per R7/R8/R9/R13.
  always @(negedge clk) begin
    if (monitor_on && rst_n && cmd_type != 3'd0) begin
      if (exq.size() == 0) begin
        chk(1'b0, "R13 unexpected command", int'(cmd_type), 0);
      end else begin
        exp_t e;
        e = exq.pop_front();
        chk(int'(cmd_type) == e.typ, rtag(e.seqtag), int'(cmd_type), e.typ);
        chk(int'(cmd_addr) == e.addr, "R11 cmd_addr", int'(cmd_addr), e.addr);
        chk(cyc == e.when, rtag(e.gaptag), cyc, e.when);
      end
    end
  end

  task automatic run_req(input int row, input int col, input bit wr, input bit pol, input int idle_k);
    int a;
    int t;
    int col_at;
    int cls;
    int wait_n;
    bit pol_chg;
    if (idle_k > 0) begin
      req_valid = 1'b0;
      repeat (idle_k) begin @(posedge clk); #1; end
    end
    pol_chg = (pol != prev_pol);
    a   = (cyc > idle_from) ? cyc : idle_from;
    nxt = a + 1;
    if (!o_v) cls = 1;
    else if (o_row == row) cls = 0;
    else cls = 2;
    if (cls == 2) exp_cmd(4, 0, 4, t);
    if (cls != 0) exp_cmd(1, row, (cls == 2) ? 4 : 3, t);
    // R14 read/write code follows req_write for every class
    exp_cmd(wr ? 3 : 2, col, (cls == 0) ? 2 : 14, col_at);
    if (pol) begin
      exp_cmd(4, 0, pol_chg ? 12 : 6, t);
      idle_from = t + 1;
      o_v = 1'b0;
    end else begin
      idle_from = col_at + 1;
      o_v   = 1'b1;
      o_row = row;
    end
    prev_pol   = pol;
    close_page = pol;
    req_row    = 12'(row);
    req_col    = 12'(col);
    req_write  = wr;
    req_valid  = 1'b1;
    wait_n = 0;
    do begin
      @(negedge clk);
      wait_n++;
    end while (!req_ready && wait_n < 80);
    // R10 acknowledge cycle and class code (00 hit, 01 empty, 10 conflict)
    chk(req_ready == 1'b1 && cyc == col_at, "R10 ack cycle", cyc, col_at);
    if (pol_chg)
      chk(int'(acc_class) == cls, "R12 class after policy change", int'(acc_class), cls);
    else if (cls == 0)
      chk(int'(acc_class) == cls, "R5 hit class", int'(acc_class), cls);
    else
      chk(int'(acc_class) == cls, "R10 class", int'(acc_class), cls);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  int rows [4] = '{0, 1, 2, 4095};

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    close_page = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_row = '0;
    req_col = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(cmd_type == 3'd0, "R1 cmd in reset", int'(cmd_type), 0);
    chk(req_ready == 1'b0, "R1 ready in reset", int'(req_ready), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    monitor_on = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(cmd_type == 3'd0 && req_ready == 1'b0, "R1 idle after reset", int'(cmd_type), 0);
    end
    @(posedge clk); #1;
    for (int pass = 0; pass < 3; pass++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          bit pol;
          pol = (pass == 2) ? bit'((a ^ b) & 1) : bit'(pass);
          run_req(rows[a], a * 16 + b, bit'(b & 1), pol, (a + b) % 3);
          run_req(rows[b], 2048 + a * 4 + b, bit'(a & 1), pol, (a * b) % 3);
        end
      end
    end
    // R6 drain: trailing precharge issued, and R13 nothing further
    req_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(exq.size() == 0, "R6 pending commands", exq.size(), 0);
    chk(cmd_type == 3'd0, "R13 quiet when idle", int'(cmd_type), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule